// File: doc/BRIEF.md
# UART Command and Status Controller

This block is the register and control core that sits between a host bus and the bit-level parts of a simple UART. It has a 64-byte window on a single-cycle synchronous bus. The window holds two mode registers reached through a pointer, a status register, a command register, a transmit/receive data port, and an interrupt status register that shares its offset with a mask register. A write to the command register is split into a miscellaneous action field and separate enable/disable fields for the transmitter and the receiver.

Bytes to transmit are held in one holding register and offered to an external serializer over a valid/ready handshake. Received bytes and break events arrive from the deserializer and go into a small receive queue, which the host drains by reading the data port. One level-sensitive interrupt line is raised whenever an enabled interrupt source is active. Baud generation, bit timing, line error detection, input-change tracking, clock selection and auxiliary control are not part of this block. Writes to their offsets are accepted and have no effect.

Top module: `uart_cmd_stat`

## Requirements
- R1: After reset the status byte reads 0x08, the mode pointer selects mode register 1, both mode registers and the mask are 0x00, both directions are disabled, and irq, tx_valid and rx_ready are low.
- R2: The status byte at offset 0x04 has bit0 = receive queue not empty, bit1 = receive queue full, bit2 = transmitter enabled and bit3 = transmit holding register empty. Bits 7:4 always read 0.
- R3: Each read or write at offset 0x00 reaches mode register 1 while the pointer is at its home position and mode register 2 otherwise. After any such access the pointer moves to mode register 2 and stays there until a command with bits[6:4] = 1 returns it home.
- R4: A command write at offset 0x08 applies bits[6:4] first: 2 empties the receive queue, 3 disables the transmitter and marks the holding register empty, and 5 clears the delta-break flag. The values 0, 4, 6 and 7 change nothing. The enable fields are applied after this action.
- R5: Command bits[3:2] act on the transmitter and bits[1:0] on the receiver: 1 enables and 2 disables. The values 0 and 3 leave the enable state unchanged.
- R6: A write to offset 0x0C loads the holding register and clears the empty flag. tx_valid is high exactly when the transmitter is enabled and the holding register is not empty. A handshake (tx_valid and tx_ready) sets the empty flag on the next clock unless a new byte is written in the same cycle.
- R7: The receive queue holds RXQ_DEPTH bytes (default 4). rx_ready is high when the receiver is enabled, the queue is not full and no break is signalled. A read at offset 0x0C returns the oldest byte and removes it, and returns 0x00 when the queue is empty.
- R8: An rx_break pulse stores a 0x00 byte even when the receiver is disabled. When the queue is full, this byte overwrites the newest entry. It also sets the delta-break flag, and this takes priority over a clear command in the same cycle.
- R9: Interrupt status at offset 0x14 reads bit0 = transmitter enabled, bit2 = delta-break flag, and bit1 = queue full if mode register 1 bit6 is set, otherwise queue not empty. All other bits read 0. A write at 0x14 loads the interrupt mask.
- R10: irq is high exactly when the interrupt status AND the mask is nonzero. It follows a state change on the clock edge that causes it.
- R11: Writes at offsets 0x04, 0x10 and every unmapped offset change no state. Reads at 0x08, 0x10 and unmapped offsets return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset in the register window |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the access cycle |
| rx_valid | input | 1 | Deserializer offers a byte |
| rx_data | input | 8 | Offered receive byte |
| rx_break | input | 1 | One-cycle break event from the line |
| rx_ready | output | 1 | Receive byte is taken in this cycle |
| tx_valid | output | 1 | Byte offered to the serializer |
| tx_data | output | 8 | Offered transmit byte |
| tx_ready | input | 1 | Serializer takes the offered byte |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions assume that every input is at a known value once reset is released, and that at most one bus access happens per cycle. They also assume that a byte waiting on tx_valid changes only through a bus access. For that reason the hold check on the transmit byte looks only at cycles with no bus access. The bench changes every input just after the falling edge and keeps the address set to the mapped offsets plus one unmapped offset. It places idle cycles between bus accesses so that the stall, break and queue-full properties are exercised as well as the bus paths. rx_break is driven as single-cycle pulses, and rx_valid and tx_ready are driven freely.

// File: rtl/uart_cc_pkg.sv
package uart_cc_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 6;

    // register window offsets
    localparam logic [ADDR_W-1:0] OFS_MODE = 6'h00;
    localparam logic [ADDR_W-1:0] OFS_STAT = 6'h04;
    localparam logic [ADDR_W-1:0] OFS_CMD  = 6'h08;
    localparam logic [ADDR_W-1:0] OFS_DATA = 6'h0C;
    localparam logic [ADDR_W-1:0] OFS_AUX  = 6'h10;
    localparam logic [ADDR_W-1:0] OFS_INT  = 6'h14;

    // status bit positions
    localparam int ST_RXNE  = 0;
    localparam int ST_RXFUL = 1;
    localparam int ST_TXON  = 2;
    localparam int ST_TXEMP = 3;

    // interrupt status bit positions
    localparam int IS_TX  = 0;
    localparam int IS_RX  = 1;
    localparam int IS_BRK = 2;

    // mode register 1 bit choosing the receive interrupt source
    localparam int MR1_RXSRC = 6;

    typedef struct packed {
        logic ptr_home;
        logic rx_flush;
        logic tx_reset;
        logic brk_ack;
        logic tx_on;
        logic tx_off;
        logic rx_on;
        logic rx_off;
    } cmd_act_t;

endpackage

// File: rtl/uart_cc_cmd.sv
module uart_cc_cmd
    import uart_cc_pkg::*;
(
    input  logic              wr,
    input  logic [BYTE_W-1:0] code,
    output cmd_act_t          act
);

    logic [2:0] misc_f;
    logic [1:0] tx_f;
    logic [1:0] rx_f;

    always_comb begin
        misc_f = code[6:4];
        tx_f   = code[3:2];
        rx_f   = code[1:0];
        act    = '0;
        if (wr) begin
            act.ptr_home = (misc_f == 3'd1);
            act.rx_flush = (misc_f == 3'd2);
            act.tx_reset = (misc_f == 3'd3);
            act.brk_ack  = (misc_f == 3'd5);
            act.tx_on    = (tx_f == 2'd1);
            act.tx_off   = (tx_f == 2'd2);
            act.rx_on    = (rx_f == 2'd1);
            act.rx_off   = (rx_f == 2'd2);
        end
    end

endmodule

// File: rtl/uart_cc_rxq.sv
module uart_cc_rxq #(
    parameter int DEPTH = 4,
    parameter int W     = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          flush,
    input  logic                          pop,
    input  logic                          put,
    input  logic [W-1:0]                  put_data,
    output logic [W-1:0]                  head,
    output logic [$clog2(DEPTH+1)-1:0]    count,
    output logic                          full,
    output logic                          empty
);

    localparam int CW = $clog2(DEPTH + 1);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [CW-1:0]           cnt;
    } rxq_t;

    rxq_t s_d, s_q;
    logic [CW-1:0] cnt_mid;

    always_comb begin
        s_d     = s_q;
        cnt_mid = s_q.cnt;
        if (flush) begin
            s_d.cnt = '0;
        end else begin
            if (pop && (s_q.cnt != '0)) begin
                for (int i = 0; i < DEPTH - 1; i++) begin
                    s_d.mem[i] = s_q.mem[i+1];
                end
                cnt_mid = s_q.cnt - 1'b1;
            end
            s_d.cnt = cnt_mid;
            if (put) begin
                if (cnt_mid == CW'(DEPTH)) begin
                    s_d.mem[DEPTH-1] = put_data;
                end else begin
                    s_d.mem[cnt_mid[AW-1:0]] = put_data;
                    s_d.cnt = cnt_mid + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign count = s_q.cnt;
    assign empty = (s_q.cnt == '0);
    assign full  = (s_q.cnt == CW'(DEPTH));
    assign head  = empty ? '0 : s_q.mem[0];

    AST_RXQ_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= CW'(DEPTH)); // R7

    AST_RXQ_FULL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (put && !pop && !flush && full) |=> full); // R8

endmodule

// File: rtl/uart_cmd_stat.sv
module uart_cmd_stat
    import uart_cc_pkg::*;
#(
    parameter int RXQ_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [5:0]        bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_break,
    output logic              rx_ready,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    input  logic              tx_ready,
    output logic              irq
);

    localparam int CW = $clog2(RXQ_DEPTH + 1);

    typedef struct packed {
        logic [BYTE_W-1:0] mr1;
        logic [BYTE_W-1:0] mr2;
        logic              ptr;
        logic              tx_en;
        logic              rx_en;
        logic              tx_empty;
        logic [BYTE_W-1:0] tx_hold;
        logic              dbrk;
        logic [BYTE_W-1:0] imr;
    } ctl_t;

    ctl_t s_d, s_q;

    logic        wr_acc, rd_acc;
    logic        cmd_wr, data_wr, data_rd, mode_acc;
    cmd_act_t    act;
    logic        q_put, q_full, q_empty;
    logic [7:0]  q_put_data, q_head;
    logic [CW-1:0] q_count;
    logic [7:0]  status, int_stat;

    assign wr_acc   = bus_sel && bus_we;
    assign rd_acc   = bus_sel && !bus_we;
    assign cmd_wr   = wr_acc && (bus_addr == OFS_CMD);
    assign data_wr  = wr_acc && (bus_addr == OFS_DATA);
    assign data_rd  = rd_acc && (bus_addr == OFS_DATA);
    assign mode_acc = bus_sel && (bus_addr == OFS_MODE);

    uart_cc_cmd u_cmd (
        .wr   (cmd_wr),
        .code (bus_wdata),
        .act  (act)
    );

    assign rx_ready   = s_q.rx_en && !q_full && !rx_break;
    assign q_put      = rx_break || (rx_valid && rx_ready);
    assign q_put_data = rx_break ? '0 : rx_data;

    uart_cc_rxq #(.DEPTH(RXQ_DEPTH), .W(BYTE_W)) u_rxq (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (act.rx_flush),
        .pop      (data_rd),
        .put      (q_put),
        .put_data (q_put_data),
        .head     (q_head),
        .count    (q_count),
        .full     (q_full),
        .empty    (q_empty)
    );

    assign tx_valid = s_q.tx_en && !s_q.tx_empty;
    assign tx_data  = s_q.tx_hold;

    always_comb begin
        status            = '0;
        status[ST_RXNE]   = !q_empty;
        status[ST_RXFUL]  = q_full;
        status[ST_TXON]   = s_q.tx_en;
        status[ST_TXEMP]  = s_q.tx_empty;
        int_stat          = '0;
        int_stat[IS_TX]   = s_q.tx_en;
        int_stat[IS_RX]   = s_q.mr1[MR1_RXSRC] ? q_full : !q_empty;
        int_stat[IS_BRK]  = s_q.dbrk;
    end

    assign irq = |(int_stat & s_q.imr);

    always_comb begin
        case (bus_addr)
            OFS_MODE: bus_rdata = s_q.ptr ? s_q.mr2 : s_q.mr1;
            OFS_STAT: bus_rdata = status;
            OFS_DATA: bus_rdata = q_head;
            OFS_INT:  bus_rdata = int_stat;
            default:  bus_rdata = '0;
        endcase
    end

    always_comb begin
        s_d = s_q;
        if (mode_acc) begin
            if (bus_we) begin
                if (s_q.ptr) s_d.mr2 = bus_wdata;
                else         s_d.mr1 = bus_wdata;
            end
            s_d.ptr = 1'b1;
        end
        if (tx_valid && tx_ready) s_d.tx_empty = 1'b1;
        if (data_wr) begin
            s_d.tx_hold  = bus_wdata;
            s_d.tx_empty = 1'b0;
        end
        if (wr_acc && (bus_addr == OFS_INT)) s_d.imr = bus_wdata;
        // miscellaneous action first, then enable fields
        if (act.ptr_home) s_d.ptr = 1'b0;
        if (act.tx_reset) begin
            s_d.tx_en    = 1'b0;
            s_d.tx_empty = 1'b1;
        end
        if (act.brk_ack) s_d.dbrk  = 1'b0;
        if (act.tx_on)   s_d.tx_en = 1'b1;
        if (act.tx_off)  s_d.tx_en = 1'b0;
        if (act.rx_on)   s_d.rx_en = 1'b1;
        if (act.rx_off)  s_d.rx_en = 1'b0;
        if (rx_break)    s_d.dbrk  = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q          <= '0;
            s_q.tx_empty <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    AST_PTR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ptr && !act.ptr_home) |=> s_q.ptr); // R3

    AST_RXQ_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        act.rx_flush |=> (q_count == '0)); // R4

    AST_TXBUF_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        data_wr |=> !status[ST_TXEMP]); // R6

    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && !bus_sel) |=> (tx_valid && $stable(tx_data))); // R6

    AST_BRK_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        rx_break |=> int_stat[IS_BRK]); // R8

endmodule

// File: tb/tb_uart_cmd_stat.sv
`timescale 1ns/100ps
module tb_uart_cmd_stat;

    localparam int DEPTH = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_we = 1'b0;
    logic [5:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       rx_valid = 1'b0, rx_break = 1'b0, tx_ready = 1'b0;
    logic [7:0] rx_data = '0;
    logic       rx_ready, tx_valid, irq;
    logic [7:0] tx_data;

    always #2 clk = ~clk;

    uart_cmd_stat #(.RXQ_DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_break(rx_break),
        .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_ready(tx_ready), .irq(irq)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    string cur_req = "";

    // behavioural reference state
    logic [7:0] m_mr1, m_mr2, m_hold, m_imr;
    logic       m_ptr, m_txen, m_rxen, m_txe, m_dbrk;
    logic [7:0] q[$];

    task automatic model_reset();
        m_mr1 = 0; m_mr2 = 0; m_hold = 0; m_imr = 0;
        m_ptr = 0; m_txen = 0; m_rxen = 0; m_txe = 1; m_dbrk = 0;
        q.delete();
    endtask

    function automatic logic [7:0] e_status();
        return {4'b0, m_txe, m_txen, q.size() == DEPTH, q.size() != 0};
    endfunction

    function automatic logic [7:0] e_isr();
        logic rxi;
        rxi = m_mr1[6] ? (q.size() == DEPTH) : (q.size() != 0);
        return {5'b0, m_dbrk, rxi, m_txen};
    endfunction

    function automatic logic [7:0] e_rdata(logic [5:0] a);
        case (a)
            6'h00: return m_ptr ? m_mr2 : m_mr1;
            6'h04: return e_status();
            6'h0C: return (q.size() != 0) ? q[0] : 8'h00;
            6'h14: return e_isr();
            default: return 8'h00;
        endcase
    endfunction

    function automatic string addr_req(logic [5:0] a);
        case (a)
            6'h00: return "R3";
            6'h04: return "R2";
            6'h0C: return "R7";
            6'h14: return "R9";
            default: return "R11";
        endcase
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // one clock: compare before the rising edge, then advance the model
    task automatic step();
        logic p_rxrdy, p_txv, flush;
        #1;
        p_rxrdy = m_rxen && (q.size() < DEPTH) && !rx_break;
        p_txv   = m_txen && !m_txe;
        chk("R7", "rx_ready", rx_ready, p_rxrdy);
        chk("R6", "tx_valid", tx_valid, p_txv);
        if (p_txv) chk("R6", "tx_data", tx_data, m_hold);
        chk("R10", "irq", irq, |(e_isr() & m_imr));
        if (bus_sel && !bus_we)
            chk((cur_req != "") ? cur_req : addr_req(bus_addr), "rdata",
                bus_rdata, e_rdata(bus_addr));
        @(posedge clk);
        flush = 0;
        if (bus_sel && bus_addr == 6'h00) begin
            if (bus_we) begin
                if (m_ptr) m_mr2 = bus_wdata; else m_mr1 = bus_wdata;
            end
            m_ptr = 1;
        end
        if (p_txv && tx_ready) m_txe = 1;
        if (bus_sel && bus_we && bus_addr == 6'h0C) begin m_hold = bus_wdata; m_txe = 0; end
        if (bus_sel && bus_we && bus_addr == 6'h14) m_imr = bus_wdata;
        if (bus_sel && bus_we && bus_addr == 6'h08) begin
            case (bus_wdata[6:4])
                3'd1: m_ptr = 0;
                3'd2: flush = 1;
                3'd3: begin m_txen = 0; m_txe = 1; end
                3'd5: m_dbrk = 0;
                default: ;
            endcase
            case (bus_wdata[3:2]) 2'd1: m_txen = 1; 2'd2: m_txen = 0; default: ; endcase
            case (bus_wdata[1:0]) 2'd1: m_rxen = 1; 2'd2: m_rxen = 0; default: ; endcase
        end
        if (flush) q.delete();
        else begin
            if (bus_sel && !bus_we && bus_addr == 6'h0C && q.size() > 0) void'(q.pop_front());
            if (rx_break) begin
                if (q.size() == DEPTH) q[DEPTH-1] = 8'h00; else q.push_back(8'h00);
            end else if (rx_valid && p_rxrdy) q.push_back(rx_data);
        end
        if (rx_break) m_dbrk = 1;
        @(negedge clk);
        bus_sel = 0; bus_we = 0; rx_valid = 0; rx_break = 0; cur_req = "";
    endtask

    task automatic wr(logic [5:0] a, logic [7:0] d);
        bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d; step();
    endtask

    task automatic rd(logic [5:0] a, string req);
        bus_sel = 1; bus_we = 0; bus_addr = a; cur_req = req; step();
    endtask

    task automatic rxb(logic [7:0] d);
        rx_valid = 1; rx_data = d; step();
    endtask

    task automatic brk();
        rx_break = 1; step();
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        step();
        rd(6'h04, "R1");
        rd(6'h14, "R1");
        rd(6'h00, "R1");          // mode reg 1 after reset
        wr(6'h08, 8'h10);         // pointer home
        // R3 pointer walk
        wr(6'h00, 8'hA5);
        wr(6'h00, 8'h3C);
        rd(6'h00, "R3");
        wr(6'h08, 8'h10);
        rd(6'h00, "R3");
        rd(6'h00, "R3");
        // R5/R6 transmitter
        wr(6'h14, 8'h07);
        wr(6'h0C, 8'h55);
        rd(6'h04, "R6");          // pending but disabled
        wr(6'h08, 8'h04);
        rd(6'h04, "R5");
        step(); step();
        tx_ready = 1; step();
        tx_ready = 0; rd(6'h04, "R6");
        wr(6'h08, 8'h0C);         // reserved tx value
        rd(6'h04, "R5");
        wr(6'h0C, 8'h66);
        wr(6'h08, 8'h30);         // reset transmitter
        rd(6'h04, "R4");
        wr(6'h08, 8'h34);         // reset then enable
        rd(6'h04, "R4");
        wr(6'h08, 8'h08);
        rd(6'h04, "R5");
        // R7 receive queue
        rd(6'h0C, "R7");          // empty read
        rxb(8'h11);               // disabled: dropped
        wr(6'h08, 8'h01);
        rxb(8'h21); rxb(8'h22); rxb(8'h23); rxb(8'h24); rxb(8'h25);
        rd(6'h04, "R2");
        rd(6'h0C, "R7");
        rd(6'h0C, "R7");
        wr(6'h08, 8'h03);         // reserved rx value
        rxb(8'h26); rxb(8'h27);
        rd(6'h04, "R5");
        // R9 receive interrupt source
        wr(6'h08, 8'h10);
        wr(6'h00, 8'h40);
        rd(6'h14, "R9");
        // R8 break
        brk();
        rd(6'h0C, "R8"); rd(6'h0C, "R8"); rd(6'h0C, "R8"); rd(6'h0C, "R8");
        rd(6'h14, "R8");
        wr(6'h08, 8'h50);
        rd(6'h14, "R4");
        wr(6'h08, 8'h02);
        brk();
        rd(6'h04, "R8");
        bus_sel = 1; bus_we = 1; bus_addr = 6'h08; bus_wdata = 8'h50; rx_break = 1; step();
        rd(6'h14, "R8");
        wr(6'h08, 8'h20);         // flush
        rd(6'h04, "R4");
        wr(6'h08, 8'h40); wr(6'h08, 8'h60); wr(6'h08, 8'h70); wr(6'h08, 8'h00);
        rd(6'h04, "R4"); rd(6'h14, "R4");
        // R11 ignored offsets
        wr(6'h04, 8'hFF); wr(6'h10, 8'hFF); wr(6'h3C, 8'hFF);
        rd(6'h04, "R11"); rd(6'h10, "R11"); rd(6'h08, "R11"); rd(6'h3C, "R11");
        rd(6'h14, "R11");
        // mixed traffic
        for (int i = 0; i < 4000; i++) begin
            int r;
            logic [5:0] addrs [8];
            addrs = '{6'h00, 6'h04, 6'h08, 6'h0C, 6'h10, 6'h14, 6'h18, 6'h0C};
            r = $urandom % 100;
            tx_ready = ($urandom % 3) == 0;
            rx_valid = ($urandom % 2) == 0;
            rx_data  = 8'($urandom);
            rx_break = ($urandom % 40) == 0;
            if (r < 45) begin
                bus_sel = 1;
                bus_we = ($urandom % 2) == 0;
                bus_addr = addrs[$urandom % 8];
                bus_wdata = 8'($urandom);
                if (bus_we && bus_addr == 6'h08 && ($urandom % 2) == 0)
                    bus_wdata = 8'h05;
            end
            step();
        end
        done = 1;
        summary();
        $finish;
    end

endmodule